// File: doc/BRIEF.md
# MSI Private Cache Line Coherence Controller

This block keeps the coherence state of a small table of lines in one private cache that takes part in a directory-based MSI protocol. The table is direct-mapped. The low address bits select a line and the remaining bits form its tag. Each line stores a state, a tag and one data word.

Processor reads and writes, eviction triggers and directory messages arrive as single-cycle pulses. The block answers with registered pulses one cycle later. These are coherence messages to the directory, a completion strobe with read data to the processor, or an error strobe. While a line waits for a grant from the directory, it holds the processor operation that caused the miss and finishes that operation when the grant arrives. An invalidation that arrives during a pending upgrade makes the line drop its shared copy. The line then keeps waiting as a plain write miss.

At most one input event is taken per cycle. A directory message has the highest priority, then an eviction, then a processor request. A processor request that cannot be taken is signalled through a combinational stall output and must be held by the requester.

Top module: `msi_ctrl`

## Requirements
- R1: After reset every line is Invalid and msg_valid_o, cpu_done_o and resp_err_o are low.
- R2: Line index and tag encoding: index = addr[IDX_W-1:0] and tag = the upper bits. Read handling:
  - A read to an Invalid line sends msg_type_o=0 (shared request) with no data, and the line waits for a shared grant.
  - A read that hits a Shared or Modified line raises cpu_done_o one cycle later with the line data, and sends no message.
- R3: Write handling:
  - A write to an Invalid or Shared line sends msg_type_o=1 (exclusive request) with no data.
  - A write that hits a Modified line raises cpu_done_o one cycle later with the written word as cpu_rdata_o, sends no message and updates the line.
- R4: Invalidation is dir_type_i=2. The reply is msg_type_o=3.
  - A Modified line replies with data and becomes Invalid.
  - A Shared line replies without data and becomes Invalid.
  - Any other line replies without data and is unchanged.
- R5: Downgrade is dir_type_i=3. The reply is msg_type_o=4.
  - A Modified line replies with its data and becomes Shared.
  - Any other line replies without data and is unchanged.
- R6: Eviction of a hit Modified line sends msg_type_o=2 (writeback) with data. Eviction of a hit Shared line sends msg_type_o=2 without data. Both end Invalid. An eviction of any other line sends nothing and changes nothing.
- R7: An invalidation to a line whose Shared-to-Modified upgrade is pending replies without data. The line keeps waiting, now as an Invalid-to-Modified miss. The exclusive grant then completes the write and leaves the line Modified.
- R8: cpu_stall_o is high, combinationally, for a processor request in any of these cases, and the stalled request has no effect:
  - the indexed line is waiting for a grant;
  - the indexed line holds another valid tag;
  - dir_valid_i is high in the same cycle;
  - evict_i is high in the same cycle.
- R9: A grant that matches a pending line writes data into that line and raises cpu_done_o one cycle later. A shared grant is dir_type_i=0 and must match a line waiting on a read. An exclusive grant is dir_type_i=1 and must match a line waiting on a write.
  - A pending read returns the grant data and leaves the line Shared.
  - A pending write returns the written word and leaves the line Modified, holding that word.
- R10: A grant whose address matches no line pending for that kind of grant raises resp_err_o one cycle later. It does not raise cpu_done_o and does not change any line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpu_req_i | input | 1 | Processor request strobe |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | ADDR_W | Processor address |
| cpu_wdata_i | input | DATA_W | Write data |
| cpu_stall_o | output | 1 | Request not taken this cycle |
| cpu_done_o | output | 1 | Processor access completed |
| cpu_rdata_o | output | DATA_W | Completion data |
| evict_i | input | 1 | Eviction trigger |
| evict_addr_i | input | ADDR_W | Address to evict |
| dir_valid_i | input | 1 | Directory message strobe |
| dir_type_i | input | 2 | 0 shared grant, 1 exclusive grant, 2 invalidate, 3 downgrade |
| dir_addr_i | input | ADDR_W | Directory message address |
| dir_data_i | input | DATA_W | Grant data |
| msg_valid_o | output | 1 | Outgoing message strobe |
| msg_type_o | output | 3 | 0 shared req, 1 exclusive req, 2 writeback, 3 inval resp, 4 downgrade resp |
| msg_addr_o | output | ADDR_W | Message address |
| msg_has_data_o | output | 1 | Message carries data |
| msg_data_o | output | DATA_W | Message data |
| resp_err_o | output | 1 | Grant matched no pending line |

## Verification
The bench builds the block with its defaults: four lines, 8-bit addresses and 16-bit data. Four lines give two address bits of index. Addresses such as 0x33 and 0x73 therefore share a line with different tags, which exercises the conflict stall. The table is small enough that one line can be in a pending state while others are in stable states, so the upgrade race and a stray grant can be checked next to normal hits.

// File: rtl/msi_pkg.sv
package msi_pkg;
  typedef enum logic [2:0] {
    LS_I  = 3'd0,
    LS_S  = 3'd1,
    LS_M  = 3'd2,
    LS_IS = 3'd3,
    LS_IM = 3'd4,
    LS_SM = 3'd5
  } line_st_e;

  typedef enum logic [1:0] {
    DM_SH_RESP = 2'd0,
    DM_EX_RESP = 2'd1,
    DM_INV     = 2'd2,
    DM_DOWN    = 2'd3
  } dir_msg_e;

  typedef enum logic [2:0] {
    CM_SH_REQ    = 3'd0,
    CM_EX_REQ    = 3'd1,
    CM_WB_REQ    = 3'd2,
    CM_INV_RESP  = 3'd3,
    CM_DOWN_RESP = 3'd4
  } cache_msg_e;

  function automatic logic st_pending(line_st_e s);
    return (s == LS_IS) || (s == LS_IM) || (s == LS_SM);
  endfunction
endpackage

// File: rtl/msi_line.sv
module msi_line
  import msi_pkg::*;
#(
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_i,
  input  logic              we_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              inv_i,
  input  logic              down_i,
  input  logic              evict_i,
  input  logic              resp_i,
  input  logic [DATA_W-1:0] rdata_i,
  output line_st_e          state_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic [DATA_W-1:0] data_o,
  output logic              pend_we_o,
  output logic [DATA_W-1:0] pend_data_o
);
  line_st_e          st_q;
  logic [TAG_W-1:0]  tag_q;
  logic [DATA_W-1:0] data_q, pdata_q;
  logic              pwe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= LS_I;
      tag_q   <= '0;
      data_q  <= '0;
      pdata_q <= '0;
      pwe_q   <= 1'b0;
    end else if (resp_i) begin
      data_q <= pwe_q ? pdata_q : rdata_i;
      st_q   <= pwe_q ? LS_M : LS_S;
    end else if (inv_i) begin
      st_q <= (st_q == LS_SM) ? LS_IM : LS_I;
    end else if (down_i) begin
      st_q <= LS_S;
    end else if (evict_i) begin
      st_q <= LS_I;
    end else if (cpu_i) begin
      unique case (st_q)
        LS_I: begin
          tag_q   <= tag_i;
          st_q    <= we_i ? LS_IM : LS_IS;
          pwe_q   <= we_i;
          pdata_q <= wdata_i;
        end
        LS_S: if (we_i) begin
          st_q    <= LS_SM;
          pwe_q   <= 1'b1;
          pdata_q <= wdata_i;
        end
        LS_M: if (we_i) data_q <= wdata_i;
        default: ;
      endcase
    end
  end

  assign state_o     = st_q;
  assign tag_o       = tag_q;
  assign data_o      = data_q;
  assign pend_we_o   = pwe_q;
  assign pend_data_o = pdata_q;

  p_no_cpu_when_pending_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_i |-> !st_pending(st_q));
  p_race_to_im_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == LS_SM && inv_i && !resp_i) |=> (st_q == LS_IM));
  p_resp_needs_pending_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_i |-> st_pending(st_q));
endmodule

// File: rtl/msi_out_reg.sv
module msi_out_reg
  import msi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              msg_v_i,
  input  cache_msg_e        msg_t_i,
  input  logic [ADDR_W-1:0] msg_a_i,
  input  logic              msg_hd_i,
  input  logic [DATA_W-1:0] msg_d_i,
  input  logic              done_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic              err_i,
  output logic              msg_valid_o,
  output logic [2:0]        msg_type_o,
  output logic [ADDR_W-1:0] msg_addr_o,
  output logic              msg_has_data_o,
  output logic [DATA_W-1:0] msg_data_o,
  output logic              cpu_done_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              resp_err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      msg_valid_o    <= 1'b0;
      msg_type_o     <= '0;
      msg_addr_o     <= '0;
      msg_has_data_o <= 1'b0;
      msg_data_o     <= '0;
      cpu_done_o     <= 1'b0;
      cpu_rdata_o    <= '0;
      resp_err_o     <= 1'b0;
    end else begin
      msg_valid_o    <= msg_v_i;
      msg_type_o     <= msg_t_i;
      msg_addr_o     <= msg_a_i;
      msg_has_data_o <= msg_hd_i;
      msg_data_o     <= msg_d_i;
      cpu_done_o     <= done_i;
      cpu_rdata_o    <= rdata_i;
      resp_err_o     <= err_i;
    end
  end

  p_data_kind_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_o && msg_has_data_o) |->
      (msg_type_o == 3'(CM_WB_REQ) || msg_type_o == 3'(CM_INV_RESP) ||
       msg_type_o == 3'(CM_DOWN_RESP)));
  p_done_xor_msg_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(msg_valid_o && cpu_done_o));
  p_err_no_done_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_err_o |-> !cpu_done_o);
endmodule

// File: rtl/msi_ctrl.sv
module msi_ctrl
  import msi_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_stall_o,
  output logic              cpu_done_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  input  logic              evict_i,
  input  logic [ADDR_W-1:0] evict_addr_i,
  input  logic              dir_valid_i,
  input  logic [1:0]        dir_type_i,
  input  logic [ADDR_W-1:0] dir_addr_i,
  input  logic [DATA_W-1:0] dir_data_i,
  output logic              msg_valid_o,
  output logic [2:0]        msg_type_o,
  output logic [ADDR_W-1:0] msg_addr_o,
  output logic              msg_has_data_o,
  output logic [DATA_W-1:0] msg_data_o,
  output logic              resp_err_o
);
  localparam int IDX_W = $clog2(NUM_LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  line_st_e          st  [NUM_LINES];
  logic [TAG_W-1:0]  tg  [NUM_LINES];
  logic [DATA_W-1:0] dt  [NUM_LINES];
  logic [DATA_W-1:0] pdt [NUM_LINES];
  logic [NUM_LINES-1:0] pwe;
  logic [NUM_LINES-1:0] cpu_v, inv_v, down_v, evict_v, resp_v;

  logic [IDX_W-1:0] d_idx, e_idx, c_idx;
  logic [TAG_W-1:0] d_tag, e_tag, c_tag;
  line_st_e         d_st, e_st, c_st;
  logic             d_hit, e_hit, c_hit, c_busy;
  dir_msg_e         d_type;

  assign d_idx  = dir_addr_i[IDX_W-1:0];
  assign d_tag  = dir_addr_i[ADDR_W-1:IDX_W];
  assign e_idx  = evict_addr_i[IDX_W-1:0];
  assign e_tag  = evict_addr_i[ADDR_W-1:IDX_W];
  assign c_idx  = cpu_addr_i[IDX_W-1:0];
  assign c_tag  = cpu_addr_i[ADDR_W-1:IDX_W];
  assign d_st   = st[d_idx];
  assign e_st   = st[e_idx];
  assign c_st   = st[c_idx];
  assign d_hit  = (tg[d_idx] == d_tag);
  assign e_hit  = (tg[e_idx] == e_tag);
  assign c_hit  = (tg[c_idx] == c_tag);
  assign d_type = dir_msg_e'(dir_type_i);
  // in Invalid the stored tag is stale and does not block a new miss
  assign c_busy = st_pending(c_st) || (c_st != LS_I && !c_hit);
  assign cpu_stall_o = cpu_req_i && (dir_valid_i || evict_i || c_busy);

  logic              n_msg_v, n_msg_hd, n_done, n_err;
  cache_msg_e        n_msg_t;
  logic [ADDR_W-1:0] n_msg_a;
  logic [DATA_W-1:0] n_msg_d, n_rdata;

  always_comb begin
    cpu_v = '0; inv_v = '0; down_v = '0; evict_v = '0; resp_v = '0;
    n_msg_v = 1'b0; n_msg_t = CM_SH_REQ; n_msg_a = '0; n_msg_hd = 1'b0; n_msg_d = '0;
    n_done = 1'b0; n_rdata = '0; n_err = 1'b0;
    if (dir_valid_i) begin
      unique case (d_type)
        DM_SH_RESP, DM_EX_RESP: begin
          if (d_hit && ((d_type == DM_SH_RESP) ? (d_st == LS_IS)
                                               : (d_st == LS_IM || d_st == LS_SM))) begin
            resp_v[d_idx] = 1'b1;
            n_done  = 1'b1;
            n_rdata = pwe[d_idx] ? pdt[d_idx] : dir_data_i;
          end else begin
            n_err = 1'b1;
          end
        end
        DM_INV: begin
          n_msg_v = 1'b1;
          n_msg_t = CM_INV_RESP;
          n_msg_a = dir_addr_i;
          if (d_hit && d_st == LS_M) begin
            n_msg_hd = 1'b1;
            n_msg_d  = dt[d_idx];
          end
          if (d_hit && (d_st == LS_M || d_st == LS_S || d_st == LS_SM))
            inv_v[d_idx] = 1'b1;
        end
        default: begin
          n_msg_v = 1'b1;
          n_msg_t = CM_DOWN_RESP;
          n_msg_a = dir_addr_i;
          if (d_hit && d_st == LS_M) begin
            n_msg_hd = 1'b1;
            n_msg_d  = dt[d_idx];
            down_v[d_idx] = 1'b1;
          end
        end
      endcase
    end else if (evict_i) begin
      if (e_hit && (e_st == LS_S || e_st == LS_M)) begin
        evict_v[e_idx] = 1'b1;
        n_msg_v  = 1'b1;
        n_msg_t  = CM_WB_REQ;
        n_msg_a  = evict_addr_i;
        n_msg_hd = (e_st == LS_M);
        n_msg_d  = (e_st == LS_M) ? dt[e_idx] : '0;
      end
    end else if (cpu_req_i && !c_busy) begin
      unique case (c_st)
        LS_I: begin
          cpu_v[c_idx] = 1'b1;
          n_msg_v = 1'b1;
          n_msg_t = cpu_we_i ? CM_EX_REQ : CM_SH_REQ;
          n_msg_a = cpu_addr_i;
        end
        LS_S: begin
          if (cpu_we_i) begin
            cpu_v[c_idx] = 1'b1;
            n_msg_v = 1'b1;
            n_msg_t = CM_EX_REQ;
            n_msg_a = cpu_addr_i;
          end else begin
            n_done  = 1'b1;
            n_rdata = dt[c_idx];
          end
        end
        default: begin
          n_done = 1'b1;
          if (cpu_we_i) begin
            cpu_v[c_idx] = 1'b1;
            n_rdata = cpu_wdata_i;
          end else begin
            n_rdata = dt[c_idx];
          end
        end
      endcase
    end
  end

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    msi_line #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_line (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .cpu_i       (cpu_v[g]),
      .we_i        (cpu_we_i),
      .tag_i       (c_tag),
      .wdata_i     (cpu_wdata_i),
      .inv_i       (inv_v[g]),
      .down_i      (down_v[g]),
      .evict_i     (evict_v[g]),
      .resp_i      (resp_v[g]),
      .rdata_i     (dir_data_i),
      .state_o     (st[g]),
      .tag_o       (tg[g]),
      .data_o      (dt[g]),
      .pend_we_o   (pwe[g]),
      .pend_data_o (pdt[g])
    );
  end

  msi_out_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_out (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .msg_v_i        (n_msg_v),
    .msg_t_i        (n_msg_t),
    .msg_a_i        (n_msg_a),
    .msg_hd_i       (n_msg_hd),
    .msg_d_i        (n_msg_d),
    .done_i         (n_done),
    .rdata_i        (n_rdata),
    .err_i          (n_err),
    .msg_valid_o    (msg_valid_o),
    .msg_type_o     (msg_type_o),
    .msg_addr_o     (msg_addr_o),
    .msg_has_data_o (msg_has_data_o),
    .msg_data_o     (msg_data_o),
    .cpu_done_o     (cpu_done_o),
    .cpu_rdata_o    (cpu_rdata_o),
    .resp_err_o     (resp_err_o)
  );

  p_one_event_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({|cpu_v, |inv_v, |down_v, |evict_v, |resp_v}) <= 1);
endmodule

// File: tb/msi_ctrl_tb.sv
module msi_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 0, cpu_we = 0, evict = 0, dir_valid = 0;
  logic [7:0]  cpu_addr = 0, evict_addr = 0, dir_addr = 0;
  logic [15:0] cpu_wdata = 0, dir_data = 0;
  logic [1:0]  dir_type = 0;
  logic        cpu_stall, cpu_done, msg_valid, msg_has_data, resp_err;
  logic [15:0] cpu_rdata, msg_data;
  logic [2:0]  msg_type;
  logic [7:0]  msg_addr;
  int checks = 0, errors = 0;
  logic stall_seen;
  bit finished = 0;

  always #2.5 clk = ~clk;

  msi_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata),
    .cpu_stall_o(cpu_stall), .cpu_done_o(cpu_done), .cpu_rdata_o(cpu_rdata),
    .evict_i(evict), .evict_addr_i(evict_addr),
    .dir_valid_i(dir_valid), .dir_type_i(dir_type), .dir_addr_i(dir_addr), .dir_data_i(dir_data),
    .msg_valid_o(msg_valid), .msg_type_o(msg_type), .msg_addr_o(msg_addr),
    .msg_has_data_o(msg_has_data), .msg_data_o(msg_data), .resp_err_o(resp_err)
  );

  task automatic chk(string r, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    cpu_req = 0; evict = 0; dir_valid = 0;
  endtask

  task automatic do_cpu(logic we, logic [7:0] a, logic [15:0] d);
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    #1 stall_seen = cpu_stall;
    tick();
  endtask

  task automatic do_dir(logic [1:0] t, logic [7:0] a, logic [15:0] d);
    dir_valid = 1; dir_type = t; dir_addr = a; dir_data = d;
    tick();
  endtask

  task automatic do_evict(logic [7:0] a);
    evict = 1; evict_addr = a;
    tick();
  endtask

  task automatic exp_msg(string r, int t, logic [7:0] a, logic hd, logic [15:0] d);
    chk(r, "msg_valid", msg_valid, 1);
    chk(r, "msg_type", msg_type, t);
    chk(r, "msg_addr", msg_addr, a);
    chk(r, "msg_has_data", msg_has_data, hd);
    if (hd) chk(r, "msg_data", msg_data, d);
    chk(r, "cpu_done", cpu_done, 0);
  endtask

  task automatic exp_done(string r, logic [15:0] d);
    chk(r, "cpu_done", cpu_done, 1);
    chk(r, "cpu_rdata", cpu_rdata, d);
    chk(r, "msg_valid", msg_valid, 0);
    chk(r, "resp_err", resp_err, 0);
  endtask

  task automatic exp_idle(string r);
    chk(r, "msg_valid", msg_valid, 0);
    chk(r, "cpu_done", cpu_done, 0);
  endtask

  task automatic t_reset();
    exp_idle("R1");
    chk("R1", "resp_err", resp_err, 0);
    do_cpu(0, 8'h40, 0);   // line 0 must be Invalid: shared request
    exp_msg("R1", 0, 8'h40, 0, 0);
    do_dir(0, 8'h40, 16'h0001);
    exp_done("R1", 16'h0001);
  endtask

  task automatic t_read_path();
    do_cpu(0, 8'h11, 0);
    exp_msg("R2", 0, 8'h11, 0, 0);
    do_cpu(0, 8'h11, 0);
    chk("R8", "stall pending", stall_seen, 1);
    exp_idle("R8");
    do_dir(0, 8'h11, 16'hAAAA);
    exp_done("R9", 16'hAAAA);
    do_cpu(0, 8'h11, 0);
    chk("R2", "stall on hit", stall_seen, 0);
    exp_done("R2", 16'hAAAA);
  endtask

  task automatic t_write_down_inv();
    do_cpu(1, 8'h11, 16'h1234);
    exp_msg("R3", 1, 8'h11, 0, 0);
    do_dir(1, 8'h11, 16'hAAAA);
    exp_done("R9", 16'h1234);
    do_cpu(1, 8'h11, 16'h5678);
    exp_done("R3", 16'h5678);
    do_dir(3, 8'h11, 0);
    exp_msg("R5", 4, 8'h11, 1, 16'h5678);
    do_cpu(0, 8'h11, 0);
    exp_done("R5", 16'h5678);
    do_dir(3, 8'h11, 0);
    exp_msg("R5", 4, 8'h11, 0, 0);
    do_dir(2, 8'h11, 0);
    exp_msg("R4", 3, 8'h11, 0, 0);
    do_cpu(0, 8'h11, 0);
    exp_msg("R4", 0, 8'h11, 0, 0);
    do_dir(0, 8'h11, 16'h0F0F);
    exp_done("R9", 16'h0F0F);
  endtask

  task automatic t_inv_modified();
    do_cpu(1, 8'h22, 16'hBEEF);
    exp_msg("R3", 1, 8'h22, 0, 0);
    do_dir(1, 8'h22, 16'h0000);
    exp_done("R9", 16'hBEEF);
    do_dir(2, 8'h22, 0);
    exp_msg("R4", 3, 8'h22, 1, 16'hBEEF);
    do_cpu(1, 8'h22, 16'hCAFE);
    exp_msg("R4", 1, 8'h22, 0, 0);
    do_dir(1, 8'h22, 16'h0000);
    exp_done("R9", 16'hCAFE);
  endtask

  task automatic t_evict();
    do_evict(8'h22);
    exp_msg("R6", 2, 8'h22, 1, 16'hCAFE);
    do_evict(8'h22);
    exp_idle("R6");
    do_evict(8'h11);
    exp_msg("R6", 2, 8'h11, 0, 0);
    do_cpu(0, 8'h11, 0);
    exp_msg("R6", 0, 8'h11, 0, 0);
    do_dir(0, 8'h11, 16'h7777);
    exp_done("R6", 16'h7777);
  endtask

  task automatic t_race();
    do_cpu(0, 8'h33, 0);
    exp_msg("R7", 0, 8'h33, 0, 0);
    do_dir(0, 8'h33, 16'h1111);
    exp_done("R7", 16'h1111);
    do_cpu(1, 8'h33, 16'h2222);
    exp_msg("R7", 1, 8'h33, 0, 0);
    do_dir(2, 8'h33, 0);
    exp_msg("R7", 3, 8'h33, 0, 0);
    do_cpu(0, 8'h33, 0);
    chk("R7", "stall after race", stall_seen, 1);
    exp_idle("R7");
    do_dir(1, 8'h33, 16'h9999);
    exp_done("R7", 16'h2222);
    do_dir(3, 8'h33, 0);
    exp_msg("R7", 4, 8'h33, 1, 16'h2222);
  endtask

  task automatic t_error();
    do_dir(0, 8'h80, 16'h5555);      // line 0 is Shared, tag differs
    chk("R10", "resp_err", resp_err, 1);
    chk("R10", "cpu_done", cpu_done, 0);
    do_dir(1, 8'h33, 16'h5555);      // line is Shared, not pending
    chk("R10", "resp_err kind", resp_err, 1);
    do_cpu(0, 8'h33, 0);
    exp_done("R10", 16'h2222);
    do_dir(0, 8'h40, 16'h5555);      // line 0 Shared with this tag, not pending
    chk("R10", "resp_err stable", resp_err, 1);
    do_cpu(0, 8'h40, 0);
    exp_done("R10", 16'h0001);
  endtask

  task automatic t_stall();
    do_cpu(0, 8'h73, 0);             // same line as 0x33, other tag
    chk("R8", "stall conflict", stall_seen, 1);
    exp_idle("R8");
    dir_valid = 1; dir_type = 2; dir_addr = 8'h73; dir_data = 0;
    do_cpu(0, 8'h33, 0);             // simultaneous with directory message
    chk("R8", "stall dir", stall_seen, 1);
    exp_msg("R8", 3, 8'h73, 0, 0);
    evict = 1; evict_addr = 8'h22;
    do_cpu(1, 8'h22, 16'h3333);      // line 2 Invalid; eviction takes the cycle
    chk("R8", "stall evict", stall_seen, 1);
    exp_idle("R8");
    do_cpu(0, 8'h33, 0);
    exp_done("R8", 16'h2222);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_read_path();
    t_write_down_inv();
    t_inv_modified();
    t_evict();
    t_race();
    t_error();
    t_stall();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule